// File: doc/BRIEF.md
# Serial PRBS Error-Count Receiver

This block takes a received serial bit stream, one bit per cycle in which `in_valid` is high. It locks a local reference to the incoming pseudo-random sequence, which is produced by an 11-stage register with recurrence b[n] = b[n-11] XOR b[n-9]. Once locked, it counts errors against that reference. Lock is acquired by self-seeding. Received bits are loaded into the reference register, and the register's own predictions are then checked against the stream until a run of correct predictions proves the alignment.

While locked, the reference runs freely and every received bit is compared with the predicted bit. The error count is assessed over consecutive windows of a programmable length. When a window ends with more bad bits than a programmable percentage of its length, the receiver declares loss of lock, counts a resync event and starts acquiring again.

Three saturating counters report the results: bits checked, bad bits and resync events. An optional bit limit ends the measurement. One-cycle pulses mark each gain and each loss of lock.

Top module: `bert_rx`

## Requirements
- R1: After reset, `synced`, `sync_pulse`, `unsync_pulse` and `done` are 0, and all three counters read 0.
- R2: On a clean stream, the first 11 valid bits fill the reference, and the next 32 must each match the prediction. `synced` rises on the edge that takes the 43rd valid bit, and `sync_pulse` is high for exactly the following cycle.
- R3: A prediction mismatch during the checking phase restarts acquisition with the next valid bit. On a clean stream after that, `synced` rises on the 43rd valid bit that follows the mismatching bit. A corrupted bit loaded during the fill phase causes such a mismatch when it is first used in a prediction.
- R4: A stream of all zeros never produces lock, because a reference register holding only zeros never counts as a correct prediction.
- R5: While synced, each valid bit adds one to `total_bits`, and each bit that differs from the prediction adds one to `bad_bits`. The reference runs freely, so one flipped bit costs exactly one bad bit.
- R6: The counters advance only for bits received while already synced. The bit that completes lock is not counted.
- R7: Windows run over `win_len` counted bits, starting at lock. At the end of a window the threshold is floor(`win_len`*`err_pct`/100). A bad count strictly above the threshold, including the window's last bit, clears `synced`, pulses `unsync_pulse` for one cycle and adds one to `resyncs`. A count equal to the threshold keeps lock. The last bit of the window is itself counted.
- R8: After a loss of lock, acquisition restarts with a fresh fill phase, so a clean stream relocks on its 43rd valid bit.
- R9: With `limit` nonzero, `done` rises on the edge where `total_bits` reaches `limit`. From then on, valid bits change no counter and no lock state. A `limit` of 0 means no limit.
- R10: Cycles with `in_valid` low change no counter, no lock state and raise no pulse, whatever `in_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Received serial bit |
| win_len | input | 16 | Window length in counted bits (0 disables window checks) |
| err_pct | input | 7 | Allowed bad-bit percentage per window |
| limit | input | 24 | Bit count that ends the test (0 = unlimited) |
| synced | output | 1 | Receiver is locked to the stream |
| sync_pulse | output | 1 | One-cycle pulse after lock is gained |
| unsync_pulse | output | 1 | One-cycle pulse after lock is lost |
| done | output | 1 | Bit limit reached; counters frozen |
| total_bits | output | 24 | Bits checked while synced |
| bad_bits | output | 24 | Mismatching bits while synced |
| resyncs | output | 24 | Number of lock losses |

## Verification
The bench probes the window boundary with a bad count exactly at the threshold, then one above it, with the final error placed on the window's closing bit. A design using >= instead of >, or evaluating the window before adding its last bit, would keep or drop lock at the wrong time. Corruptions are placed in the fill phase and in the checking phase, so the relock time reveals whether acquisition restarts cleanly. An all-zero stream shows whether the receiver can falsely lock onto the degenerate state. Isolated flipped bits while locked show whether the reference is fed from the stream, which would triple the error count, and the limit test shows whether bits after `done` still leak into the counters.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  typedef enum logic [1:0] {
    ACQ_FILL  = 2'd0,
    ACQ_CHECK = 2'd1,
    LOCKED    = 2'd2
  } rx_state_e;

  // Bad-bit allowance for one window: floor(len * pct / 100).
  function automatic logic [31:0] win_allow(input logic [31:0] len, input logic [6:0] pct);
    logic [38:0] prod;
    prod = {7'd0, len} * {32'd0, pct};
    return 32'(prod / 39'd100);
  endfunction

endpackage

// File: rtl/bert_ref_tracker.sv
module bert_ref_tracker
  import bert_rx_pkg::*;
#(
  parameter int SEQ_LEN  = 11,
  parameter int SEQ_TAP  = 9,
  parameter int LOCK_RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic drop_lock,
  output logic locked,
  output logic bit_err,
  output logic lock_evt
);
  localparam int FW = $clog2(SEQ_LEN + 1);
  localparam int GW = $clog2(LOCK_RUN + 1);
  localparam logic [FW-1:0] FILL_LAST = FW'(SEQ_LEN - 1);
  localparam logic [GW-1:0] RUN_LAST  = GW'(LOCK_RUN - 1);

  rx_state_e            state;
  logic [SEQ_LEN-1:0]   ref_q;
  logic [FW-1:0]        fill_q;
  logic [GW-1:0]        good_q;
  logic                 pred;
  logic                 pred_ok;

  assign pred     = ref_q[SEQ_LEN-1] ^ ref_q[SEQ_TAP-1];
  assign pred_ok  = (bit_in == pred) && (|ref_q);
  assign bit_err  = (bit_in != pred);
  assign locked   = (state == LOCKED);
  assign lock_evt = bit_vld && (state == ACQ_CHECK) && pred_ok && (good_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ACQ_FILL;
      ref_q  <= '0;
      fill_q <= '0;
      good_q <= '0;
    end else if (bit_vld) begin
      unique case (state)
        ACQ_FILL: begin
          ref_q  <= {ref_q[SEQ_LEN-2:0], bit_in};
          fill_q <= fill_q + FW'(1);
          if (fill_q == FILL_LAST) begin
            state  <= ACQ_CHECK;
            good_q <= '0;
          end
        end
        ACQ_CHECK: begin
          ref_q <= {ref_q[SEQ_LEN-2:0], bit_in};
          if (pred_ok) begin
            if (good_q == RUN_LAST) state <= LOCKED;
            else                    good_q <= good_q + GW'(1);
          end else begin
            state  <= ACQ_FILL;
            fill_q <= '0;
          end
        end
        default: begin
          ref_q <= {ref_q[SEQ_LEN-2:0], pred};
          if (drop_lock) begin
            state  <= ACQ_FILL;
            fill_q <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bert_window_mon.sv
module bert_window_mon
  import bert_rx_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             err,
  input  logic             restart,
  input  logic [WIN_W-1:0] win_len,
  input  logic [6:0]       err_pct,
  output logic             too_many
);
  logic [WIN_W-1:0] wcnt_q;
  logic [WIN_W-1:0] wbad_q;
  logic [WIN_W-1:0] bad_now;
  logic             closing;

  assign bad_now  = wbad_q + WIN_W'(err);
  assign closing  = sample && (win_len != '0) && ((wcnt_q + WIN_W'(1)) == win_len);
  assign too_many = closing && (32'(bad_now) > win_allow(32'(win_len), err_pct));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      wcnt_q <= '0;
      wbad_q <= '0;
    end else if (sample) begin
      if (closing) begin
        wcnt_q <= '0;
        wbad_q <= '0;
      end else begin
        wcnt_q <= wcnt_q + WIN_W'(1);
        wbad_q <= bad_now;
      end
    end
  end
endmodule

// File: rtl/bert_result_counters.sv
module bert_result_counters #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             err,
  input  logic             resync_evt,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] total_q,
  output logic [CNT_W-1:0] bad_q,
  output logic [CNT_W-1:0] resync_q,
  output logic             done_q
);
  logic [CNT_W-1:0] total_next;

  assign total_next = (&total_q) ? total_q : total_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q  <= '0;
      bad_q    <= '0;
      resync_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (sample) begin
        total_q <= total_next;
        if (err && !(&bad_q)) bad_q <= bad_q + CNT_W'(1);
        if ((limit != '0) && (total_next >= limit)) done_q <= 1'b1;
      end
      if (resync_evt && !(&resync_q)) resync_q <= resync_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bert_rx.sv
module bert_rx
  import bert_rx_pkg::*;
#(
  parameter int SEQ_LEN  = 11,
  parameter int SEQ_TAP  = 9,
  parameter int LOCK_RUN = 32,
  parameter int WIN_W    = 16,
  parameter int CNT_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic [WIN_W-1:0] win_len,
  input  logic [6:0]       err_pct,
  input  logic [CNT_W-1:0] limit,
  output logic             synced,
  output logic             sync_pulse,
  output logic             unsync_pulse,
  output logic             done,
  output logic [CNT_W-1:0] total_bits,
  output logic [CNT_W-1:0] bad_bits,
  output logic [CNT_W-1:0] resyncs
);
  logic bit_vld;
  logic locked;
  logic bit_err;
  logic lock_evt;
  logic loss_evt;
  logic too_many;
  logic counted;

  assign bit_vld  = in_valid && !done;
  assign counted  = bit_vld && locked;
  assign loss_evt = counted && too_many;
  assign synced   = locked;

  bert_ref_tracker #(.SEQ_LEN(SEQ_LEN), .SEQ_TAP(SEQ_TAP), .LOCK_RUN(LOCK_RUN)) u_track (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(in_bit),
    .drop_lock(too_many), .locked(locked), .bit_err(bit_err), .lock_evt(lock_evt)
  );

  bert_window_mon #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .sample(counted), .err(bit_err), .restart(lock_evt),
    .win_len(win_len), .err_pct(err_pct), .too_many(too_many)
  );

  bert_result_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sample(counted), .err(bit_err), .resync_evt(loss_evt),
    .limit(limit), .total_q(total_bits), .bad_q(bad_bits), .resync_q(resyncs), .done_q(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_pulse   <= 1'b0;
      unsync_pulse <= 1'b0;
    end else begin
      sync_pulse   <= lock_evt;
      unsync_pulse <= loss_evt;
    end
  end
endmodule

// File: rtl/bert_rx_chk.sv
module bert_rx_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             synced,
  input logic             sync_pulse,
  input logic             unsync_pulse,
  input logic             done,
  input logic [CNT_W-1:0] total_bits,
  input logic [CNT_W-1:0] bad_bits,
  input logic [CNT_W-1:0] resyncs,
  input logic             lock_evt,
  input logic             loss_evt
);
  // R2
  lock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> (synced && sync_pulse));
  // R7
  loss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> (!synced && unsync_pulse && resyncs != '0));
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_pulse && unsync_pulse));
  // R5
  bad_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_bits <= total_bits);
  // R6
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |=> $stable(total_bits));
  // R9
  done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(total_bits) && $stable(bad_bits) && $stable(synced) && done));
  // R10
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(synced) && $stable(total_bits) && $stable(resyncs)));
endmodule

bind bert_rx bert_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .synced(synced), .sync_pulse(sync_pulse),
  .unsync_pulse(unsync_pulse), .done(done), .total_bits(total_bits), .bad_bits(bad_bits),
  .resyncs(resyncs), .lock_evt(lock_evt), .loss_evt(loss_evt)
);

// File: tb/tb_bert_rx.sv
`timescale 1ns/1ps
module tb_bert_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic [15:0] win_len = 16'd100;
  logic [6:0]  err_pct = 7'd5;
  logic [23:0] limit = 24'd0;
  logic        synced, sync_pulse, unsync_pulse, done;
  logic [23:0] total_bits, bad_bits, resyncs;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [10:0] gen;

  always #10 clk = ~clk;

  bert_rx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .win_len(win_len),
    .err_pct(err_pct), .limit(limit), .synced(synced), .sync_pulse(sync_pulse),
    .unsync_pulse(unsync_pulse), .done(done), .total_bits(total_bits),
    .bad_bits(bad_bits), .resyncs(resyncs)
  );

  // columns: bits, flip period (0 none), synced, total, bad, resyncs, sync pulse, unsync pulse
  localparam int NPH = 9;
  localparam int PH [NPH][8] = '{
    '{ 42,  0, 0,   0,  0, 0, 0, 0},
    '{  1,  0, 1,   0,  0, 0, 1, 0},
    '{ 50,  0, 1,  50,  0, 0, 0, 0},
    '{ 50, 10, 1, 100,  5, 0, 0, 0},
    '{100, 20, 1, 200, 10, 0, 0, 0},
    '{100, 16, 0, 300, 16, 1, 0, 1},
    '{ 42,  0, 0, 300, 16, 1, 0, 0},
    '{  1,  0, 1, 300, 16, 1, 1, 0},
    '{ 30,  3, 1, 330, 26, 1, 0, 0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sequence model: newest bit at the top, next = b[n-11] ^ b[n-9]
  task automatic gen_bit(output logic b);
    b = gen[0] ^ gen[2];
    gen = {b, gen[10:1]};
  endtask

  task automatic send(input logic flip);
    logic b;
    gen_bit(b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b ^ flip;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    gen = 11'h5A3;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_clean(input int n);
    for (int i = 0; i < n; i++) send(1'b0);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1", "synced", synced, 0);
    chk("R1", "sync_pulse", sync_pulse, 0);
    chk("R1", "unsync_pulse", unsync_pulse, 0);
    chk("R1", "done", done, 0);
    chk("R1", "total", total_bits, 0);
    chk("R1", "bad", bad_bits, 0);
    chk("R1", "resyncs", resyncs, 0);

    // table walk: R2 lock, R5/R6 counting, R7 window, R8 relock
    for (int p = 0; p < NPH; p++) begin
      for (int i = 0; i < PH[p][0]; i++)
        send((PH[p][1] != 0) && ((i % PH[p][1]) == PH[p][1] - 1));
      settle();
      chk("R2/R8", $sformatf("phase%0d synced", p), synced, PH[p][2]);
      chk("R5/R6", $sformatf("phase%0d total", p), total_bits, PH[p][3]);
      chk("R5/R7", $sformatf("phase%0d bad", p), bad_bits, PH[p][4]);
      chk("R7", $sformatf("phase%0d resyncs", p), resyncs, PH[p][5]);
      chk("R2", $sformatf("phase%0d sync_pulse", p), sync_pulse, PH[p][6]);
      chk("R7", $sformatf("phase%0d unsync_pulse", p), unsync_pulse, PH[p][7]);
    end

    // R10 idle cycles with toggling data
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_bit = ~in_bit;
    end
    chk("R10", "synced idle", synced, 1);
    chk("R10", "total idle", total_bits, 330);
    chk("R10", "bad idle", bad_bits, 26);
    chk("R10", "sync_pulse idle", sync_pulse, 0);

    // R4 all-zero stream never locks
    do_reset();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = 1'b0;
    end
    settle();
    chk("R4", "synced zeros", synced, 0);

    // R3 error in checking phase at bit 20 -> lock at bit 63
    do_reset();
    for (int i = 1; i <= 62; i++) send(i == 20);
    settle();
    chk("R3", "synced after 62", synced, 0);
    send(1'b0);
    settle();
    chk("R3", "synced after 63", synced, 1);

    // R3 error in fill phase at bit 5 -> mismatch at 14 -> lock at bit 57
    do_reset();
    for (int i = 1; i <= 56; i++) send(i == 5);
    settle();
    chk("R3", "synced after 56", synced, 0);
    send(1'b0);
    settle();
    chk("R3", "synced after 57", synced, 1);

    // R9 bit limit of 20
    do_reset();
    limit = 24'd20;
    send_clean(43 + 19);
    settle();
    chk("R9", "total before limit", total_bits, 19);
    chk("R9", "done before limit", done, 0);
    send_clean(1);
    for (int i = 0; i < 10; i++) send(1'b1);
    settle();
    chk("R9", "total at limit", total_bits, 20);
    chk("R9", "bad after done", bad_bits, 0);
    chk("R9", "done", done, 1);
    chk("R9", "synced frozen", synced, 1);
    limit = 24'd0;

    // R7 zero percent: one error on the closing bit of a 10-bit window drops lock
    do_reset();
    win_len = 16'd10;
    err_pct = 7'd0;
    send_clean(43 + 9);
    send(1'b1);
    settle();
    chk("R7", "synced pct0", synced, 0);
    chk("R7", "resyncs pct0", resyncs, 1);
    chk("R7", "total pct0", total_bits, 10);
    chk("R7", "bad pct0", bad_bits, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule